// File: doc/BRIEF.md
# Unipolar Stepper Step/Direction Indexer

This block converts a step-and-direction command stream into the four winding-on signals of a unipolar stepper motor. The command inputs are a step strobe that may arrive with no relation to the clock, a direction level and a two-bit excitation mode. Each rising edge of the strobe moves the motor one position forward or backward. A position index is decoded into a winding pattern for the selected excitation sequence. An active-low home flag reports when the index sits at the first position of its sequence.

All three sequences share one three-bit index, so the mode may be changed while the motor holds a position. A fault-side inhibit input and the block's own reset both freeze the index. A separate active-low output enable forces every winding off without disturbing the index. The whole block is synchronous to one clock, and its reset is synchronous and active high.

Top module: `stepper_indexer`

## Requirements
- R1: Mode code 2'b00 selects the two-winding full-step sequence. Bit k of `wind_on_o` drives winding k+1. Positions 1 to 4 show 4'b1001, 4'b0011, 4'b0110 and 4'b1100.
- R2: Mode code 2'b01 selects the eight-position half-step sequence, shown in order: 4'b0001, 4'b0011, 4'b0010, 4'b0110, 4'b0100, 4'b1100, 4'b1000, 4'b1001.
- R3: Mode code 2'b10 selects wave drive. Positions 1 to 4 show 4'b0001, 4'b0010, 4'b0100 and 4'b1000.
- R4: Each high period of `step_i`, however long it lasts, moves the index by exactly one position. With `dir_i`=1 the index moves forward and with `dir_i`=0 it moves backward. It wraps in both directions, and the new pattern shows within six clock cycles of the rising edge.
- R5: `home_n_o` is 0 while the index is at position 1 of the active sequence, and 1 at every other position.
- R6: While `rst_i` is high, the index returns to position 1 and `step_i` is ignored. The outputs show the home pattern of the selected mode, with code 2'b11 shown as full step, and `home_n_o` is 0.
- R7: While `step_hold_i` is 1, rising edges of `step_i` do not move the index, in any mode.
- R8: While `out_en_n_i` is 1, `wind_on_o` is 4'b0000. The index keeps following step edges, and `home_n_o` still reports position 1.
- R9: With mode code 2'b11, step edges are ignored and both `wind_on_o` and `home_n_o` keep their last values.
- R10: A mode change keeps the index modulo the new sequence length. Leaving half step keeps the low two index bits. Any step taken in a four-position mode leaves the index below 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_i | input | 1 | Synchronous active-high reset; returns the index to position 1 |
| step_i | input | 1 | Step strobe, asynchronous, rising edge moves one position |
| dir_i | input | 1 | Direction: 1 forward, 0 backward |
| mode_i | input | 2 | Excitation mode: 00 full, 01 half, 10 wave, 11 reserved |
| out_en_n_i | input | 1 | Active-low winding output enable |
| step_hold_i | input | 1 | Step inhibit from fault logic, active high |
| wind_on_o | output | 4 | Winding-on signals, bit k is winding k+1 |
| home_n_o | output | 1 | Active-low home indication |

## Verification
The step pulse and a mode change can both act on the index in the same clock cycle. In that case the counter must apply the wrap rule of the new mode, not the old one. The bench sets up this collision by parking the half-step index at position 5 (index 4) and raising `step_i`. It switches the mode to wave drive in the cycle in which the synchronised pulse is live. It then returns to half step: the pattern 4'b0011 shows that the two-bit rule was applied and the upper index bit cleared, while 4'b1100 would expose the eight-position rule.

// File: rtl/stp_pkg.sv
package stp_pkg;

   localparam int unsigned PHASES = 4;
   localparam int unsigned IDX_W  = 3;

   typedef enum logic [1:0] {
      MODE_FULL = 2'b00,
      MODE_HALF = 2'b01,
      MODE_WAVE = 2'b10,
      MODE_RSVD = 2'b11
   } step_mode_e;

   // Eight-position half-step pattern; even entries energise one winding,
   // odd entries energise that winding and its next neighbour.
   function automatic logic [PHASES-1:0] half_pattern(input logic [IDX_W-1:0] h);
      logic [PHASES-1:0] base;
      base = {{(PHASES-1){1'b0}}, 1'b1} << h[IDX_W-1:1];
      if (h[0]) return base | {base[PHASES-2:0], base[PHASES-1]};
      return base;
   endfunction

   // Four-position modes pick every other half-step entry: wave takes the
   // even entries, full step the odd ones shifted back by one.
   function automatic logic [PHASES-1:0] phase_decode(input logic [IDX_W-1:0] idx,
                                                      input step_mode_e mode);
      logic [IDX_W-1:0] even_idx;
      even_idx = {idx[IDX_W-2:0], 1'b0};
      case (mode)
         MODE_HALF: return half_pattern(idx);
         MODE_WAVE: return half_pattern(even_idx);
         default:   return half_pattern(even_idx - 3'd1);
      endcase
   endfunction

   function automatic logic at_home(input logic [IDX_W-1:0] idx, input step_mode_e mode);
      if (mode == MODE_HALF) return idx == '0;
      return idx[IDX_W-2:0] == '0;
   endfunction

endpackage

// File: rtl/stp_step_sync.sv
module stp_step_sync #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic step_i,
   output logic rise_o
);

   localparam int unsigned CHAIN_W = SYNC_STAGES + 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("stp_step_sync: SYNC_STAGES must be at least 2");
      end
   endgenerate

   // chain_q[SYNC_STAGES-1] is the synchronised level, the top bit its previous value
   logic [CHAIN_W-1:0] chain_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) chain_q <= '0;
      else       chain_q <= {chain_q[CHAIN_W-2:0], step_i};
   end

   assign rise_o = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

   AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
      rise_o |=> !rise_o); // R4

endmodule

// File: rtl/stp_position.sv
module stp_position
   import stp_pkg::*;
(
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             adv_i,
   input  logic             dir_i,
   input  step_mode_e       mode_i,
   output logic [IDX_W-1:0] idx_o
);

   logic [IDX_W-1:0]   idx_q;
   logic [IDX_W-1:0]   idx_d;
   logic [IDX_W-2:0]   short_idx;
   logic               long_seq;

   assign long_seq  = (mode_i == MODE_HALF);
   assign short_idx = idx_q[IDX_W-2:0];

   always_comb begin
      if (long_seq) idx_d = dir_i ? idx_q + 1'b1 : idx_q - 1'b1;
      else          idx_d = {1'b0, (dir_i ? short_idx + 1'b1 : short_idx - 1'b1)};
   end

   always_ff @(posedge clk_i) begin
      if (rst_i)      idx_q <= '0;
      else if (adv_i) idx_q <= idx_d;
   end

   assign idx_o = idx_q;

   AST_STEP_MOVES: assert property (@(posedge clk_i) disable iff (rst_i)
      adv_i |=> idx_q != $past(idx_q)); // R4
   AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (rst_i)
      !adv_i |=> $stable(idx_q)); // R7
   AST_SHORT_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
      (adv_i && mode_i != MODE_HALF) |=> !idx_q[IDX_W-1]); // R10

endmodule

// File: rtl/stp_phase_map.sv
module stp_phase_map
   import stp_pkg::*;
#(
   parameter int unsigned NUM_WINDINGS = 4
) (
   input  logic                    clk_i,
   input  logic                    rst_i,
   input  logic [IDX_W-1:0]        idx_i,
   input  step_mode_e              mode_i,
   input  logic                    out_en_n_i,
   output logic [NUM_WINDINGS-1:0] wind_on_o,
   output logic                    home_n_o
);

   generate
      if (NUM_WINDINGS != PHASES) begin : g_bad_windings
         $error("stp_phase_map: NUM_WINDINGS must equal the package phase count");
      end
   endgenerate

   logic [NUM_WINDINGS-1:0] pat_q;
   logic                    home_n_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         pat_q    <= phase_decode('0, mode_i);
         home_n_q <= 1'b0;
      end else if (mode_i != MODE_RSVD) begin
         pat_q    <= phase_decode(idx_i, mode_i);
         home_n_q <= !at_home(idx_i, mode_i);
      end
   end

   assign wind_on_o = out_en_n_i ? '0 : pat_q;
   assign home_n_o  = home_n_q;

   AST_OUT_OFF: assert property (@(posedge clk_i) disable iff (rst_i)
      out_en_n_i |-> wind_on_o == '0); // R8
   AST_HOME_W1: assert property (@(posedge clk_i) disable iff (rst_i)
      !home_n_o |-> pat_q[0]); // R5
   AST_PAT_COUNT: assert property (@(posedge clk_i) disable iff (rst_i)
      ($countones(pat_q) >= 1) && ($countones(pat_q) <= 2)); // R1
   AST_RSVD_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
      (mode_i == MODE_RSVD) |=> ($stable(pat_q) && $stable(home_n_q))); // R9

endmodule

// File: rtl/stepper_indexer.sv
module stepper_indexer
   import stp_pkg::*;
#(
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned NUM_WINDINGS = 4
) (
   input  logic                    clk_i,
   input  logic                    rst_i,
   input  logic                    step_i,
   input  logic                    dir_i,
   input  logic [1:0]              mode_i,
   input  logic                    out_en_n_i,
   input  logic                    step_hold_i,
   output logic [NUM_WINDINGS-1:0] wind_on_o,
   output logic                    home_n_o
);

   step_mode_e       mode;
   logic             rise;
   logic             adv;
   logic [IDX_W-1:0] pos_q;

   assign mode = step_mode_e'(mode_i);
   assign adv  = rise & ~step_hold_i & (mode != MODE_RSVD);

   stp_step_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .step_i (step_i),
      .rise_o (rise)
   );

   stp_position u_pos (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .adv_i  (adv),
      .dir_i  (dir_i),
      .mode_i (mode),
      .idx_o  (pos_q)
   );

   stp_phase_map #(.NUM_WINDINGS(NUM_WINDINGS)) u_map (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .idx_i      (pos_q),
      .mode_i     (mode),
      .out_en_n_i (out_en_n_i),
      .wind_on_o  (wind_on_o),
      .home_n_o   (home_n_o)
   );

   AST_INHIBIT_FREEZE: assert property (@(posedge clk_i) disable iff (rst_i)
      (step_hold_i || mode_i == 2'b11) |=> $stable(pos_q)); // R7

endmodule

// File: tb/stepper_indexer_tb.sv
module stepper_indexer_tb_top;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       step = 1'b0;
   logic       dir = 1'b1;
   logic [1:0] mode = 2'b00;
   logic       en_n = 1'b0;
   logic       hold = 1'b0;
   logic [3:0] wind;
   logic       home_n;

   int vectors = 0;
   int errs    = 0;

   localparam logic [3:0] FULL_SEQ [4] = '{4'b1001, 4'b0011, 4'b0110, 4'b1100};
   localparam logic [3:0] WAVE_SEQ [4] = '{4'b0001, 4'b0010, 4'b0100, 4'b1000};
   localparam logic [3:0] HALF_SEQ [8] = '{4'b0001, 4'b0011, 4'b0010, 4'b0110,
                                           4'b0100, 4'b1100, 4'b1000, 4'b1001};

   always #(CLK_PERIOD/2) clk = ~clk;

   stepper_indexer dut_i (
      .clk_i       (clk),
      .rst_i       (rst),
      .step_i      (step),
      .dir_i       (dir),
      .mode_i      (mode),
      .out_en_n_i  (en_n),
      .step_hold_i (hold),
      .wind_on_o   (wind),
      .home_n_o    (home_n)
   );

   task automatic chk(input logic [3:0] ew, input logic eh, input string tag);
      vectors++;
      if (wind !== ew || home_n !== eh) begin
         errs++;
         $display("FAIL %s: wind=%b home_n=%b expected wind=%b home_n=%b",
                  tag, wind, home_n, ew, eh);
      end
   endtask

   task automatic do_reset(input logic [1:0] m);
      mode = m;
      rst  = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
   endtask

   task automatic do_step(input logic d);
      @(negedge clk);
      dir  = d;
      step = 1'b1;
      repeat (4) @(negedge clk);
      step = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_full;
      do_reset(2'b00);
      chk(4'b1001, 1'b0, "R6 full reset state");
      for (int i = 1; i <= 4; i++) begin
         do_step(1'b1);
         chk(FULL_SEQ[i % 4], (i % 4) != 0, "R1 R4 R5 full forward");
      end
      for (int i = 3; i >= 0; i--) begin
         do_step(1'b0);
         chk(FULL_SEQ[i], i != 0, "R1 R4 R5 full backward");
      end
   endtask

   task automatic t_half;
      do_reset(2'b01);
      chk(4'b0001, 1'b0, "R6 half reset state");
      for (int i = 1; i <= 8; i++) begin
         do_step(1'b1);
         chk(HALF_SEQ[i % 8], (i % 8) != 0, "R2 R4 half forward");
      end
      for (int i = 7; i >= 5; i--) begin
         do_step(1'b0);
         chk(HALF_SEQ[i], 1'b1, "R2 R4 half backward wrap");
      end
   endtask

   task automatic t_wave;
      do_reset(2'b10);
      chk(4'b0001, 1'b0, "R6 wave reset state");
      for (int i = 1; i <= 4; i++) begin
         do_step(1'b1);
         chk(WAVE_SEQ[i % 4], (i % 4) != 0, "R3 wave forward");
      end
      do_step(1'b0);
      chk(4'b1000, 1'b1, "R3 R4 wave backward wrap");
   endtask

   task automatic t_long_high;
      do_reset(2'b00);
      @(negedge clk);
      dir  = 1'b1;
      step = 1'b1;
      repeat (30) @(negedge clk);
      step = 1'b0;
      repeat (4) @(negedge clk);
      chk(4'b0011, 1'b1, "R4 long high period one step");
   endtask

   task automatic t_reset_ignores;
      do_reset(2'b00);
      do_step(1'b1);
      rst = 1'b1;
      do_step(1'b1);
      do_step(1'b1);
      chk(4'b1001, 1'b0, "R6 step ignored during reset");
      mode = 2'b11;
      repeat (2) @(negedge clk);
      chk(4'b1001, 1'b0, "R6 reserved code in reset shows full home");
      rst = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_inhibit;
      do_reset(2'b01);
      do_step(1'b1);
      hold = 1'b1;
      do_step(1'b1);
      do_step(1'b1);
      chk(4'b0011, 1'b1, "R7 inhibit ignores steps");
      hold = 1'b0;
      do_step(1'b1);
      chk(4'b0010, 1'b1, "R7 steps resume after inhibit");
   endtask

   task automatic t_enable;
      do_reset(2'b00);
      en_n = 1'b1;
      @(negedge clk);
      chk(4'b0000, 1'b0, "R8 disabled at home");
      do_step(1'b1);
      do_step(1'b1);
      chk(4'b0000, 1'b1, "R8 disabled while stepping");
      en_n = 1'b0;
      @(negedge clk);
      chk(4'b0110, 1'b1, "R8 counter tracked while disabled");
   endtask

   task automatic t_reserved;
      do_reset(2'b00);
      do_step(1'b1);
      mode = 2'b11;
      repeat (2) @(negedge clk);
      chk(4'b0011, 1'b1, "R9 reserved holds pattern");
      do_step(1'b1);
      do_step(1'b0);
      do_step(1'b0);
      chk(4'b0011, 1'b1, "R9 reserved ignores steps");
      mode = 2'b00;
      repeat (2) @(negedge clk);
      chk(4'b0011, 1'b1, "R9 index unchanged after reserved");
   endtask

   task automatic t_mode_change;
      do_reset(2'b01);
      for (int i = 0; i < 5; i++) do_step(1'b1);
      chk(4'b1100, 1'b1, "R10 half index 5 before switch");
      mode = 2'b00;
      repeat (2) @(negedge clk);
      chk(4'b0011, 1'b1, "R10 half to full keeps low bits");
      do_step(1'b1);
      chk(4'b0110, 1'b1, "R10 full step from kept index");
      mode = 2'b01;
      repeat (2) @(negedge clk);
      chk(4'b0010, 1'b1, "R10 upper bit cleared by short step");
   endtask

   task automatic t_collide;
      do_reset(2'b01);
      for (int i = 0; i < 4; i++) do_step(1'b1);
      chk(4'b0100, 1'b1, "R2 half index 4 before collision");
      @(negedge clk);
      dir  = 1'b1;
      step = 1'b1;
      repeat (2) @(negedge clk);
      mode = 2'b10;
      repeat (2) @(negedge clk);
      step = 1'b0;
      repeat (4) @(negedge clk);
      chk(4'b0010, 1'b1, "R3 R10 step and mode change same cycle");
      mode = 2'b01;
      repeat (2) @(negedge clk);
      chk(4'b0011, 1'b1, "R10 new mode wrap rule applied");
   endtask

   initial begin
      repeat (2) @(negedge clk);
      t_full();
      t_half();
      t_wave();
      t_long_high();
      t_reset_ignores();
      t_inhibit();
      t_enable();
      t_reserved();
      t_mode_change();
      t_collide();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errs++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
   end

endmodule